// File: doc/BRIEF.md
# Bus Request Phase Checker

This block sits at the front of a snooping bus agent. It watches a request phase that lasts two clocks. The wires are active low. In the clock where the address strobe is low, it captures the address lines and the request lines, and it checks both parity groups against the pin levels. In the next clock the same address lines carry the attribute, deferred-ID, byte-enable and extended-function fields, and the request lines carry the address-space and length codes. The block latches those fields and decodes the two codes.

One clock after the second request clock, the block presents a decoded request record for a single cycle. With that record it gives a respond decision that depends on the agent's address width. It also raises sticky parity-error and protocol-error flags, which hold until the later error phase consumes them. The agent's width is chosen by the parameter `SUPPORT36`.

Top module: `reqPhaseTop`

## Requirements
- R1: A strobe seen low while idle starts a request. The address output is the bitwise inverse of the address pins in that clock, and the request output is the inverse of the request pins. `recValid` is high for exactly one cycle, starting one clock after the second request clock.
- R2: In the second clock the block inverts the address pins to obtain the fields. Logical bits [10:3] are the byte enables, [18:11] the attributes, [26:19] the deferred ID and [31:27] the extended-function bits. The request pins in that clock, inverted, carry the space code in bits [4:3] and the length code in bits [1:0].
- R3: Address parity is checked in the strobe clock. The high group is A[35:24] plus `apN[1]`, and the low group is A[23:3] plus `apN[0]`. A group is correct when it has an even number of low pins. If either group is wrong, `parityErr` is set together with the record.
- R4: Request parity covers the five request pins, the strobe pin and `rpN`, using the same even-low rule. A violation sets `parityErr`.
- R5: `parityErr` and `protoErr` stay set until a cycle with `errAck` high clears them. If a new error and `errAck` occur in the same cycle, the flag ends up set.
- R6: Space code 00 means the 32-bit space and 01 means the 36-bit space. A 32-bit agent (`SUPPORT36`=0) responds only to 00. A 36-bit agent responds to 00 and 01. `respond` is high only while `recValid` is high.
- R7: The length code selects the byte enables and the byte count. Code 00 passes the byte enables through and gives their population count as `xferBytes`. Code 01 gives all eight enables and 16 bytes. Code 10 gives all eight enables and 32 bytes. Code 11 gives zero enables and 0 bytes.
- R8: A space code of 10 or 11, or a length code of 11, sets `protoErr` and suppresses `respond`.
- R9: A strobe that is still low in the second clock sets `protoErr`, suppresses `respond` and does not start a new request.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| adsN | input | 1 | Address strobe, active low |
| aN | input | 33 | Address and field lines [35:3], active low |
| reqN | input | 5 | Request lines, active low |
| apN | input | 2 | Address parity pins |
| rpN | input | 1 | Request parity pin |
| errAck | input | 1 | Error phase consumed; clears both flags |
| recValid | output | 1 | One-cycle record strobe |
| recAddr | output | 33 | Logical address [35:3] |
| recReq | output | 5 | Logical request code |
| recSpace | output | 2 | Decoded space code |
| recLen | output | 2 | Decoded length code |
| recBe | output | 8 | Effective byte enables |
| recAttr | output | 8 | Attribute field |
| recDid | output | 8 | Deferred-ID field |
| recExf | output | 5 | Extended-function field |
| xferBytes | output | 6 | Transfer size in bytes |
| respond | output | 1 | This agent answers the request |
| parityErr | output | 1 | Sticky parity error for the error phase |
| protoErr | output | 1 | Sticky protocol error |

## Verification
Two situations are hard to reach. The first is an error landing in the same clock as `errAck`. The second is a strobe held low into the second clock, where a naive design would start a new request. Directed cases aim `errAck` at the second request clock of a request with corrupted parity, and hold the strobe across both clocks. The random phase picks each parity group's corruption, the reserved codes and the acknowledge cycles independently. The flags therefore build up from mixed causes before they are cleared. A second instance built as a 32-bit agent shares the inputs, so each request is judged under both width settings.

// File: rtl/reqPhasePkg.sv
`timescale 1ns/1ps
package reqPhasePkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } phaseT;

  typedef struct packed {
    logic capAddr;
    logic capFields;
    logic dblStrobe;
  } ctrlStrobeT;

  localparam logic [1:0] SPACE_32 = 2'b00;
  localparam logic [1:0] SPACE_36 = 2'b01;
  localparam logic [1:0] LEN_SMALL = 2'b00;
  localparam logic [1:0] LEN_16 = 2'b01;
  localparam logic [1:0] LEN_32 = 2'b10;
  localparam logic [1:0] LEN_RSVD = 2'b11;
endpackage

// File: rtl/reqPhaseCtrl.sv
`timescale 1ns/1ps
module reqPhaseCtrl
  import reqPhasePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       adsN,
  output ctrlStrobeT strobes
);
  phaseT state, stateNext;

  always_comb begin
    stateNext = state;
    strobes = '0;
    case (state)
      ST_IDLE: begin
        if (!adsN) begin
          strobes.capAddr = 1'b1;
          stateNext = ST_SECOND;
        end
      end
      ST_SECOND: begin
        strobes.capFields = 1'b1;
        strobes.dblStrobe = !adsN;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/reqPhaseDatapath.sv
`timescale 1ns/1ps
module reqPhaseDatapath
  import reqPhasePkg::*;
#(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int PAR_SPLIT = 24,
  parameter int REQ_W     = 5,
  parameter int BE_W      = 8,
  parameter int ATTR_W    = 8,
  parameter int DID_W     = 8,
  parameter int EXF_W     = 5,
  parameter int BYTES_W   = 6,
  parameter bit SUPPORT36 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobes,
  input  logic                   adsN,
  input  logic [ADDR_HI:ADDR_LO] aN,
  input  logic [REQ_W-1:0]       reqN,
  input  logic [1:0]             apN,
  input  logic                   rpN,
  input  logic                   errAck,
  output logic                   recValid,
  output logic [ADDR_HI:ADDR_LO] recAddr,
  output logic [REQ_W-1:0]       recReq,
  output logic [1:0]             recSpace,
  output logic [1:0]             recLen,
  output logic [BE_W-1:0]        recBe,
  output logic [ATTR_W-1:0]      recAttr,
  output logic [DID_W-1:0]       recDid,
  output logic [EXF_W-1:0]       recExf,
  output logic [BYTES_W-1:0]     xferBytes,
  output logic                   respond,
  output logic                   parityErr,
  output logic                   protoErr
);
  localparam int BE_LO   = ADDR_LO;
  localparam int BE_HI   = BE_LO + BE_W - 1;
  localparam int ATTR_LO = BE_HI + 1;
  localparam int ATTR_HI = ATTR_LO + ATTR_W - 1;
  localparam int DID_LO  = ATTR_HI + 1;
  localparam int DID_HI  = DID_LO + DID_W - 1;
  localparam int EXF_LO  = DID_HI + 1;
  localparam int EXF_HI  = EXF_LO + EXF_W - 1;
  localparam int SPACE_HI = REQ_W - 1;
  localparam int SPACE_LO = REQ_W - 2;
  localparam logic [BYTES_W-1:0] BYTES_16 = BYTES_W'(16);
  localparam logic [BYTES_W-1:0] BYTES_32 = BYTES_W'(32);

  // Strobe-clock parity: a group is good with an even count of low pins.
  logic badHi, badLo, badReq;
  always_comb begin
    badHi  = ($countones(~{aN[ADDR_HI:PAR_SPLIT], apN[1]}) % 2) != 0;
    badLo  = ($countones(~{aN[PAR_SPLIT-1:ADDR_LO], apN[0]}) % 2) != 0;
    badReq = ($countones(~{reqN, adsN, rpN}) % 2) != 0;
  end

  // First-clock capture
  logic [ADDR_HI:ADDR_LO] addrQ;
  logic [REQ_W-1:0]       reqQ;
  logic                   parBadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      reqQ    <= '0;
      parBadQ <= 1'b0;
    end else if (strobes.capAddr) begin
      addrQ   <= ~aN;
      reqQ    <= ~reqN;
      parBadQ <= badHi | badLo | badReq;
    end
  end

  // Second-clock decode
  logic [1:0]         spaceC, lenC;
  logic [BE_W-1:0]    beRaw, beEff;
  logic [BYTES_W-1:0] bytesC;
  logic               spaceOk, spaceRsvd, lenRsvd, protoNow, respondNow;

  always_comb begin
    spaceC = ~reqN[SPACE_HI:SPACE_LO];
    lenC   = ~reqN[1:0];
    beRaw  = ~aN[BE_HI:BE_LO];
    case (lenC)
      LEN_SMALL: begin beEff = beRaw; bytesC = BYTES_W'($countones(beRaw)); end
      LEN_16:    begin beEff = '1;    bytesC = BYTES_16; end
      LEN_32:    begin beEff = '1;    bytesC = BYTES_32; end
      default:   begin beEff = '0;    bytesC = '0; end
    endcase
    spaceRsvd = spaceC[1];
    lenRsvd   = (lenC == LEN_RSVD);
    spaceOk   = (spaceC == SPACE_32) || (SUPPORT36 && (spaceC == SPACE_36));
    protoNow  = spaceRsvd | lenRsvd | strobes.dblStrobe;
    respondNow = spaceOk && !lenRsvd && !strobes.dblStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recValid  <= 1'b0;
      respond   <= 1'b0;
      recAddr   <= '0;
      recReq    <= '0;
      recSpace  <= '0;
      recLen    <= '0;
      recBe     <= '0;
      recAttr   <= '0;
      recDid    <= '0;
      recExf    <= '0;
      xferBytes <= '0;
    end else begin
      recValid <= strobes.capFields;
      respond  <= strobes.capFields && respondNow;
      if (strobes.capFields) begin
        recAddr   <= addrQ;
        recReq    <= reqQ;
        recSpace  <= spaceC;
        recLen    <= lenC;
        recBe     <= beEff;
        recAttr   <= ~aN[ATTR_HI:ATTR_LO];
        recDid    <= ~aN[DID_HI:DID_LO];
        recExf    <= ~aN[EXF_HI:EXF_LO];
        xferBytes <= bytesC;
      end
    end
  end

  // Sticky flags for the error phase; a new error beats the acknowledge.
  logic setPar, setProto;
  assign setPar   = strobes.capFields && parBadQ;
  assign setProto = strobes.capFields && protoNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      if (setPar)      parityErr <= 1'b1;
      else if (errAck) parityErr <= 1'b0;
      if (setProto)    protoErr <= 1'b1;
      else if (errAck) protoErr <= 1'b0;
    end
  end
endmodule

// File: rtl/reqPhaseTop.sv
`timescale 1ns/1ps
module reqPhaseTop
  import reqPhasePkg::*;
#(
  parameter int ADDR_HI   = 35,
  parameter int ADDR_LO   = 3,
  parameter int PAR_SPLIT = 24,
  parameter int REQ_W     = 5,
  parameter int BE_W      = 8,
  parameter int ATTR_W    = 8,
  parameter int DID_W     = 8,
  parameter int EXF_W     = 5,
  parameter int BYTES_W   = 6,
  parameter bit SUPPORT36 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   adsN,
  input  logic [ADDR_HI:ADDR_LO] aN,
  input  logic [REQ_W-1:0]       reqN,
  input  logic [1:0]             apN,
  input  logic                   rpN,
  input  logic                   errAck,
  output logic                   recValid,
  output logic [ADDR_HI:ADDR_LO] recAddr,
  output logic [REQ_W-1:0]       recReq,
  output logic [1:0]             recSpace,
  output logic [1:0]             recLen,
  output logic [BE_W-1:0]        recBe,
  output logic [ATTR_W-1:0]      recAttr,
  output logic [DID_W-1:0]       recDid,
  output logic [EXF_W-1:0]       recExf,
  output logic [BYTES_W-1:0]     xferBytes,
  output logic                   respond,
  output logic                   parityErr,
  output logic                   protoErr
);
  ctrlStrobeT strobes;

  reqPhaseCtrl uCtrl (
    .clk(clk), .rstN(rstN), .adsN(adsN), .strobes(strobes)
  );

  reqPhaseDatapath #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .PAR_SPLIT(PAR_SPLIT), .REQ_W(REQ_W),
    .BE_W(BE_W), .ATTR_W(ATTR_W), .DID_W(DID_W), .EXF_W(EXF_W),
    .BYTES_W(BYTES_W), .SUPPORT36(SUPPORT36)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adsN(adsN), .aN(aN),
    .reqN(reqN), .apN(apN), .rpN(rpN), .errAck(errAck),
    .recValid(recValid), .recAddr(recAddr), .recReq(recReq),
    .recSpace(recSpace), .recLen(recLen), .recBe(recBe), .recAttr(recAttr),
    .recDid(recDid), .recExf(recExf), .xferBytes(xferBytes),
    .respond(respond), .parityErr(parityErr), .protoErr(protoErr)
  );
endmodule

// File: rtl/reqPhaseChecker.sv
`timescale 1ns/1ps
module reqPhaseChecker #(
  parameter bit SUPPORT36 = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       adsN,
  input logic       errAck,
  input logic       recValid,
  input logic [1:0] recSpace,
  input logic [1:0] recLen,
  input logic       respond,
  input logic       parityErr,
  input logic       protoErr
);
  assert_record_after_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recValid) |-> $past(adsN, 2) == 1'b0);

  assert_record_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);

  assert_parity_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !errAck) |=> parityErr);

  assert_proto_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !errAck) |=> protoErr);

  assert_respond_needs_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    respond |-> recValid);

  assert_space_support_R6: assert property (@(posedge clk) disable iff (!rstN)
    respond |-> (recSpace == 2'b00 || (SUPPORT36 && recSpace == 2'b01)));

  assert_reserved_no_respond_R8: assert property (@(posedge clk) disable iff (!rstN)
    respond |-> (recLen != 2'b11 && !recSpace[1]));
endmodule

bind reqPhaseTop reqPhaseChecker #(.SUPPORT36(SUPPORT36)) uChk (
  .clk(clk), .rstN(rstN), .adsN(adsN), .errAck(errAck), .recValid(recValid),
  .recSpace(recSpace), .recLen(recLen), .respond(respond),
  .parityErr(parityErr), .protoErr(protoErr)
);

// File: tb/sim_reqPhaseTop.sv
`timescale 1ns/1ps
module sim_reqPhaseTop;
  logic clk = 1'b0;
  logic rstN;
  logic adsN;
  logic [35:3] aN;
  logic [4:0] reqN;
  logic [1:0] apN;
  logic rpN;
  logic errAck;

  logic recValid, respond, parityErr, protoErr;
  logic [35:3] recAddr;
  logic [4:0] recReq;
  logic [1:0] recSpace, recLen;
  logic [7:0] recBe, recAttr, recDid;
  logic [4:0] recExf;
  logic [5:0] xferBytes;

  logic n1Valid, n1Respond, n1Par, n1Proto;
  logic [35:3] n1Addr;
  logic [4:0] n1Req;
  logic [1:0] n1Space, n1Len;
  logic [7:0] n1Be, n1Attr, n1Did;
  logic [4:0] n1Exf;
  logic [5:0] n1Bytes;

  int checks = 0;
  int errors = 0;
  logic expPar = 1'b0;
  logic expProto = 1'b0;

  always #2.5 clk = ~clk;

  reqPhaseTop #(.SUPPORT36(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .adsN(adsN), .aN(aN), .reqN(reqN), .apN(apN),
    .rpN(rpN), .errAck(errAck), .recValid(recValid), .recAddr(recAddr),
    .recReq(recReq), .recSpace(recSpace), .recLen(recLen), .recBe(recBe),
    .recAttr(recAttr), .recDid(recDid), .recExf(recExf),
    .xferBytes(xferBytes), .respond(respond), .parityErr(parityErr),
    .protoErr(protoErr)
  );

  reqPhaseTop #(.SUPPORT36(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .adsN(adsN), .aN(aN), .reqN(reqN), .apN(apN),
    .rpN(rpN), .errAck(errAck), .recValid(n1Valid), .recAddr(n1Addr),
    .recReq(n1Req), .recSpace(n1Space), .recLen(n1Len), .recBe(n1Be),
    .recAttr(n1Attr), .recDid(n1Did), .recExf(n1Exf),
    .xferBytes(n1Bytes), .respond(n1Respond), .parityErr(n1Par),
    .protoErr(n1Proto)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expBe(input logic [1:0] ln, input logic [7:0] be);
    if (ln == 2'b00) return be;
    if (ln == 2'b11) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [5:0] expBytes(input logic [1:0] ln, input logic [7:0] be);
    int n = 0;
    if (ln == 2'b01) return 6'd16;
    if (ln == 2'b10) return 6'd32;
    if (ln == 2'b11) return 6'd0;
    for (int i = 0; i < 8; i++) n += int'(be[i]);
    return 6'(n);
  endfunction

  task automatic idleBus();
    adsN = 1'b1; aN = '1; reqN = '1; apN = 2'b11; rpN = 1'b1; errAck = 1'b0;
  endtask

  // corrupt: [2] high address group, [1] low address group, [0] request group
  task automatic runReq(input logic [32:0] addr, input logic [4:0] req,
                        input logic [1:0] sp, input logic [1:0] ln,
                        input logic [7:0] be, input logic [7:0] attr,
                        input logic [7:0] did, input logic [4:0] exf,
                        input logic [2:0] corrupt, input bit dbl, input bit ackMid);
    logic [32:0] fields;
    logic r36, r32;
    @(negedge clk);
    adsN = 1'b0;
    aN = ~addr;
    reqN = ~req;
    apN[1] = ~(^addr[32:21]) ^ corrupt[2];
    apN[0] = ~(^addr[20:0]) ^ corrupt[1];
    rpN = (^req) ^ corrupt[0];
    @(negedge clk);
    fields = {4'b0, exf, did, attr, be};
    adsN = dbl ? 1'b0 : 1'b1;
    aN = ~fields;
    reqN = ~{sp, 1'b0, ln};
    errAck = ackMid;
    @(negedge clk);
    idleBus();
    if (ackMid) begin expPar = 1'b0; expProto = 1'b0; end
    if (corrupt != 3'b000) expPar = 1'b1;
    if (sp[1] || ln == 2'b11 || dbl) expProto = 1'b1;
    r36 = (sp == 2'b00 || sp == 2'b01) && ln != 2'b11 && !dbl;
    r32 = (sp == 2'b00) && ln != 2'b11 && !dbl;
    chk("R1 recValid", 64'(recValid), 64'd1);
    chk("R1 recAddr", 64'(recAddr), 64'(addr));
    chk("R1 recReq", 64'(recReq), 64'(req));
    chk("R2 recAttr", 64'(recAttr), 64'(attr));
    chk("R2 recDid", 64'(recDid), 64'(did));
    chk("R2 recExf", 64'(recExf), 64'(exf));
    chk("R2 recSpace", 64'(recSpace), 64'(sp));
    chk("R2 recLen", 64'(recLen), 64'(ln));
    chk("R7 recBe", 64'(recBe), 64'(expBe(ln, be)));
    chk("R7 xferBytes", 64'(xferBytes), 64'(expBytes(ln, be)));
    chk("R3 R4 parityErr", 64'(parityErr), 64'(expPar));
    chk("R8 R9 protoErr", 64'(protoErr), 64'(expProto));
    chk("R6 respond 36-bit agent", 64'(respond), 64'(r36));
    chk("R6 respond 32-bit agent", 64'(n1Respond), 64'(r32));
    @(negedge clk);
    chk("R1 record pulse ends", 64'(recValid), 64'd0);
    if (dbl) chk("R9 no new request from held strobe", 64'(n1Valid | recValid), 64'd0);
  endtask

  task automatic ackErrors();
    @(negedge clk);
    errAck = 1'b1;
    @(negedge clk);
    errAck = 1'b0;
    expPar = 1'b0; expProto = 1'b0;
    chk("R5 parityErr cleared", 64'(parityErr), 64'd0);
    chk("R5 protoErr cleared", 64'(protoErr), 64'd0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'd20240611));
    idleBus();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 recValid reset", 64'(recValid), 64'd0);
    chk("R10 recAddr reset", 64'(recAddr), 64'd0);
    chk("R10 respond reset", 64'(respond), 64'd0);
    chk("R10 flags reset", 64'({parityErr, protoErr}), 64'd0);
    rstN = 1'b1;

    // Directed cases
    runReq(33'h1_2345_6789, 5'h0A, 2'b00, 2'b00, 8'h3C, 8'hA5, 8'h5A, 5'h11, 3'b000, 1'b0, 1'b0);
    runReq(33'h0_FFFF_FFFF, 5'h1F, 2'b01, 2'b01, 8'h00, 8'h01, 8'h80, 5'h1F, 3'b000, 1'b0, 1'b0);
    runReq(33'h0_0000_0000, 5'h00, 2'b00, 2'b10, 8'h12, 8'h00, 8'h00, 5'h00, 3'b000, 1'b0, 1'b0);
    runReq(33'h1_0000_0001, 5'h03, 2'b00, 2'b00, 8'hFF, 8'h0F, 8'hF0, 5'h05, 3'b100, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R5 parityErr held while idle", 64'(parityErr), 64'd1);
    ackErrors();
    runReq(33'h0_0F0F_0F0F, 5'h05, 2'b00, 2'b00, 8'h81, 8'h11, 8'h22, 5'h03, 3'b010, 1'b0, 1'b0);
    ackErrors();
    runReq(33'h0_0F0F_0F0F, 5'h05, 2'b00, 2'b00, 8'h81, 8'h11, 8'h22, 5'h03, 3'b001, 1'b0, 1'b0);
    ackErrors();
    runReq(33'h1_AAAA_5555, 5'h12, 2'b10, 2'b00, 8'h01, 8'h00, 8'h00, 5'h00, 3'b000, 1'b0, 1'b0);
    runReq(33'h0_1234_0000, 5'h12, 2'b11, 2'b11, 8'h01, 8'h00, 8'h00, 5'h00, 3'b000, 1'b0, 1'b0);
    ackErrors();
    runReq(33'h0_0000_1000, 5'h01, 2'b00, 2'b11, 8'h0F, 8'h00, 8'h00, 5'h00, 3'b000, 1'b0, 1'b0);
    ackErrors();
    runReq(33'h0_5555_AAAA, 5'h07, 2'b00, 2'b00, 8'h55, 8'h77, 8'h99, 5'h0A, 3'b000, 1'b1, 1'b0);
    // error raised in the same cycle as the acknowledge: set wins
    runReq(33'h0_7777_0000, 5'h09, 2'b00, 2'b00, 8'h0F, 8'h00, 8'h00, 5'h00, 3'b001, 1'b0, 1'b1);
    ackErrors();
    runReq(33'h0_7777_0000, 5'h09, 2'b01, 2'b00, 8'h0F, 8'h00, 8'h00, 5'h00, 3'b000, 1'b0, 1'b0);

    // Constrained random phase
    for (int k = 0; k < 400; k++) begin
      logic [32:0] ad;
      logic [2:0] cor;
      ad = {1'($urandom), 32'($urandom)};
      cor = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      runReq(ad, 5'($urandom), 2'($urandom), 2'($urandom), 8'($urandom),
             8'($urandom), 8'($urandom), 5'($urandom), cor,
             ($urandom % 10 == 0), ($urandom % 8 == 0));
      if ($urandom % 4 == 0) ackErrors();
      else if ($urandom % 2 == 0) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule